// File: doc/BRIEF.md
# Oversampled UART Receiver with Flagged FIFO

This block receives a fixed 8N1 serial stream and turns each character into a word held in a 64-deep queue. A free-running divider produces a sub-tick every `rate_sel + 1` clocks. Each bit lasts 14 sub-ticks. A falling edge is confirmed at the middle of the start bit, and every later bit is sampled one bit period after the previous sample point. Each stored word carries the data byte together with a framing-error flag and a break flag.

An external register unit reads the oldest word through a one-cycle read strobe. The head word is always visible on `rd_word`, with an "empty" bit that marks when no data is present. The block drives two level requests: a fill-threshold request and an idle-timeout request that counts in character times. It also drives one-cycle event pulses for overrun, framing error and break. The current fill count is always visible.

Top module: `osr_uart_rx`

## Requirements
- R1: A sub-tick occurs once every `rate_sel + 1` clocks (divider 1 to 256), and one bit lasts 14 sub-ticks. Characters sent with bit period `14*(rate_sel+1)` clocks are received correctly for any `rate_sel`.
- R2: A character has a start bit (low), 8 data bits sent LSB first, and a stop bit (high). A character with a high stop bit is stored with both flags clear, including the byte 0x00.
- R3: `rd_word` shows the oldest entry: bits 7:0 hold the data, bit 8 = 1 only when the queue is empty, bit 9 = framing error, bit 10 = break. A strobe on a non-empty queue removes that entry. With an empty queue the word is exactly 0x100, and a strobe changes neither the fill nor which entry comes next.
- R4: The queue holds 64 entries in arrival order, and `fill_level` (8 bits) equals the number of stored entries.
- R5: `trig_irq` is high exactly while the fill is at or above the threshold chosen by `trig_sel`: 0→1, 1→4, 2→8, 3→16, 4→32, and 5, 6 or 7→48.
- R6: `tmo_irq` goes high when the queue is non-empty and no character activity, push or read has occurred for N×140 sub-ticks, where `tmo_sel` gives N: 0→never, 1→4, 2→8, 3→16. A read or an empty queue clears it.
- R7: A character that completes while the queue is full, with no read in that cycle, is discarded, and `overrun_evt` pulses for one cycle.
- R8: A non-zero character whose stop bit is sampled low is stored with bit 9 set, and `frame_evt` pulses once. No new start bit is accepted until the line returns high.
- R9: A line held low through the stop position with all data bits zero stores one entry 0x400 and pulses `break_evt` once. Nothing more is captured until the line returns high.
- R10: A low pulse that does not last until sub-tick 7 of the start bit is ignored and stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_line | input | 1 | Serial input, idles high |
| rate_sel | input | 8 | Divider value; sub-tick every rate_sel+1 clocks |
| trig_sel | input | 3 | Fill-threshold select |
| tmo_sel | input | 2 | Idle-timeout select |
| rd_strobe | input | 1 | Removes the head entry at this clock edge |
| rd_word | output | 11 | Head entry {break, frame error, empty, data} |
| fill_level | output | 8 | Number of stored entries |
| trig_irq | output | 1 | Fill-threshold request |
| tmo_irq | output | 1 | Idle-timeout request |
| overrun_evt | output | 1 | One-cycle pulse: character lost to a full queue |
| frame_evt | output | 1 | One-cycle pulse: stop bit sampled low |
| break_evt | output | 1 | One-cycle pulse: break stored |

## Verification
If a queue pointer or the count goes wrong, the next clock shows `fill_level`, `trig_irq` or the head word disagreeing with a queue model in the bench, because these outputs are compared every clock between transfers. If the bit-sampling state goes wrong, the effect appears when the character completes: a wrong byte, wrong flags, a missing or extra entry, or an event pulse that was not expected. A fault in the idle counter can only be seen at the timeout boundary, hundreds of sub-ticks later, so it is checked just before and just after that point.

// File: rtl/osr_pkg.sv
// Shared types and select decoders for the oversampled receiver.
package osr_pkg;

    // Stored queue entry: flags plus received byte.
    typedef struct packed {
        logic       brk;
        logic       fe;
        logic [7:0] data;
    } rx_entry_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    // Fill threshold for the trigger request.
    function automatic logic [7:0] trig_level(input logic [2:0] sel);
        case (sel)
            3'd0:    return 8'd1;
            3'd1:    return 8'd4;
            3'd2:    return 8'd8;
            3'd3:    return 8'd16;
            3'd4:    return 8'd32;
            default: return 8'd48;
        endcase
    endfunction

    // Idle character count for the timeout request; zero disables it.
    function automatic logic [4:0] tmo_chars(input logic [1:0] sel);
        case (sel)
            2'd0:    return 5'd0;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/osr_tick_gen.sv
// Sub-tick generator: one-cycle enable every rate_i+1 clocks.
// Assumes rate_i changes only while the line is idle.
module osr_tick_gen #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    output logic              tick_o
);
    logic [RATE_W-1:0] cnt;

    assign tick_o = (cnt == rate_i);

    // Free-running divider counter, restarted on each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (tick_o) cnt <= '0;
        else             cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/osr_framer.sv
// 8N1 framer: synchronises the line, validates the start bit at its mid
// sub-tick, samples each bit SPB sub-ticks apart and classifies the stop
// position as good, framing error or break. Assumes tick_i is one cycle wide.
module osr_framer
    import osr_pkg::*;
#(
    parameter int SPB = 14
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_i,
    input  logic      rx_i,
    output logic      push_o,
    output rx_entry_t entry_o,
    output logic      fe_evt_o,
    output logic      brk_evt_o,
    output logic      busy_o
);
    localparam int SUB_W = $clog2(SPB);
    localparam int HALF  = SPB / 2;

    logic       rx_meta, rx_sync;
    rx_state_t  state;
    logic [SUB_W-1:0] sub;
    logic [2:0] bitn;
    logic [7:0] shift;

    assign busy_o = (state != RX_IDLE) || !rx_sync;

    // Two-flop synchroniser, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_meta <= 1'b1;
            rx_sync <= 1'b1;
        end else begin
            rx_meta <= rx_i;
            rx_sync <= rx_meta;
        end
    end

    // Character state machine, advanced on sub-ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            sub       <= '0;
            bitn      <= '0;
            shift     <= '0;
            push_o    <= 1'b0;
            entry_o   <= '0;
            fe_evt_o  <= 1'b0;
            brk_evt_o <= 1'b0;
        end else begin
            push_o    <= 1'b0;
            fe_evt_o  <= 1'b0;
            brk_evt_o <= 1'b0;
            if (tick_i) begin
                case (state)
                    RX_IDLE: begin
                        if (!rx_sync) begin
                            state <= RX_START;
                            sub   <= SUB_W'(1);
                        end
                    end
                    RX_START: begin
                        if (rx_sync) begin
                            state <= RX_IDLE;
                        end else if (sub == SUB_W'(HALF)) begin
                            state <= RX_DATA;
                            sub   <= '0;
                            bitn  <= '0;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (sub == SUB_W'(SPB - 1)) begin
                            sub   <= '0;
                            shift <= {rx_sync, shift[7:1]};
                            if (bitn == 3'd7) state <= RX_STOP;
                            bitn <= bitn + 1'b1;
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (sub == SUB_W'(SPB - 1)) begin
                            sub    <= '0;
                            push_o <= 1'b1;
                            if (rx_sync) begin
                                entry_o <= '{brk: 1'b0, fe: 1'b0, data: shift};
                                state   <= RX_IDLE;
                            end else if (shift == 8'h00) begin
                                entry_o   <= '{brk: 1'b1, fe: 1'b0, data: 8'h00};
                                brk_evt_o <= 1'b1;
                                state     <= RX_HOLD;
                            end else begin
                                entry_o  <= '{brk: 1'b0, fe: 1'b1, data: shift};
                                fe_evt_o <= 1'b1;
                                state    <= RX_HOLD;
                            end
                        end else begin
                            sub <= sub + 1'b1;
                        end
                    end
                    RX_HOLD: begin
                        if (rx_sync) state <= RX_IDLE;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/osr_fifo.sv
// Flagged receive queue. DEPTH must be a power of two. A write while full
// is dropped unless a read happens in the same cycle; ovf_o then pulses.
module osr_fifo
    import osr_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  rx_entry_t        entry_i,
    input  logic             pop_i,
    output rx_entry_t        head_o,
    output logic [LVL_W-1:0] fill_o,
    output logic             ovf_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    rx_entry_t       mem [DEPTH];
    logic [AW-1:0]   wp, rp;
    logic [CW-1:0]   cnt;
    logic            full, empty, do_pop, do_push;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_pop  = pop_i && !empty;
    assign do_push = push_i && (!full || do_pop);
    assign head_o  = mem[rp];
    assign fill_o  = LVL_W'(cnt);

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= entry_i;
    end

    // Pointers, count and overrun pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            cnt   <= '0;
            ovf_o <= 1'b0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            cnt   <= cnt + CW'(do_push) - CW'(do_pop);
            ovf_o <= push_i && full && !do_pop;
        end
    end
endmodule

// File: rtl/osr_irq.sv
// Request unit: fill-threshold compare and an idle counter measured in
// sub-ticks that restarts on any activity or while the queue is empty.
module osr_irq
    import osr_pkg::*;
#(
    parameter int LVL_W = 8,
    parameter int SPB   = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [LVL_W-1:0] fill_i,
    input  logic             activity_i,
    input  logic [2:0]       trig_sel_i,
    input  logic [1:0]       tmo_sel_i,
    output logic             trig_o,
    output logic             tmo_o
);
    localparam int CHAR_TICKS = SPB * 10;
    localparam int MAX_TICKS  = 16 * CHAR_TICKS;
    localparam int TMO_W      = $clog2(MAX_TICKS + 1);

    logic [TMO_W-1:0] idle_cnt, limit;
    logic             empty;

    assign empty = (fill_i == '0);

    // Idle limit in sub-ticks for the selected character count.
    always_comb limit = TMO_W'(32'(tmo_chars(tmo_sel_i)) * CHAR_TICKS);

    assign trig_o = (fill_i >= LVL_W'(trig_level(trig_sel_i)));
    assign tmo_o  = (tmo_sel_i != 2'd0) && !empty && (idle_cnt >= limit);

    // Saturating idle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)                    idle_cnt <= '0;
        else if (empty || activity_i)  idle_cnt <= '0;
        else if (tick_i && idle_cnt != TMO_W'(MAX_TICKS))
                                       idle_cnt <= idle_cnt + 1'b1;
    end
endmodule

// File: rtl/osr_uart_rx.sv
// Top: oversampled 8N1 receiver with a flagged queue and request outputs.
// Assumes rate_sel is changed only while the line is idle.
module osr_uart_rx
    import osr_pkg::*;
#(
    parameter int RATE_W = 8,
    parameter int SPB    = 14,
    parameter int DEPTH  = 64,
    parameter int LVL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [2:0]        trig_sel,
    input  logic [1:0]        tmo_sel,
    input  logic              rd_strobe,
    output logic [10:0]       rd_word,
    output logic [LVL_W-1:0]  fill_level,
    output logic              trig_irq,
    output logic              tmo_irq,
    output logic              overrun_evt,
    output logic              frame_evt,
    output logic              break_evt
);
    localparam logic [10:0] EMPTY_WORD = 11'h100;

    logic      tick, push, busy;
    rx_entry_t entry, head;

    osr_tick_gen #(.RATE_W(RATE_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .rate_i(rate_sel), .tick_o(tick)
    );

    osr_framer #(.SPB(SPB)) u_framer (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .rx_i(rx_line),
        .push_o(push), .entry_o(entry), .fe_evt_o(frame_evt),
        .brk_evt_o(break_evt), .busy_o(busy)
    );

    osr_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push), .entry_i(entry),
        .pop_i(rd_strobe), .head_o(head), .fill_o(fill_level),
        .ovf_o(overrun_evt)
    );

    osr_irq #(.LVL_W(LVL_W), .SPB(SPB)) u_irq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .fill_i(fill_level),
        .activity_i(push || rd_strobe || busy), .trig_sel_i(trig_sel),
        .tmo_sel_i(tmo_sel), .trig_o(trig_irq), .tmo_o(tmo_irq)
    );

    // Data-port word: head entry, or the empty marker.
    assign rd_word = (fill_level == '0) ? EMPTY_WORD
                                        : {head.brk, head.fe, 1'b0, head.data};
endmodule

// File: rtl/osr_uart_rx_chk.sv
// Port-level checker for osr_uart_rx, attached by bind.
module osr_uart_rx_chk #(
    parameter int DEPTH = 64,
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_strobe,
    input logic [10:0]      rd_word,
    input logic [LVL_W-1:0] fill_level,
    input logic             trig_irq,
    input logic             tmo_irq,
    input logic             overrun_evt
);
    a_r4_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    a_r3_empty_word: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0) |-> (rd_word == 11'h100));

    a_r3_read_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && fill_level != '0) |=> (fill_level <= $past(fill_level)));

    a_r7_overrun_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_evt |-> (fill_level == LVL_W'(DEPTH)));

    a_r5_trig_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        trig_irq |-> (fill_level != '0));

    a_r6_tmo_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_irq |-> (fill_level != '0));
endmodule

bind osr_uart_rx osr_uart_rx_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .rd_word(rd_word),
    .fill_level(fill_level), .trig_irq(trig_irq), .tmo_irq(tmo_irq),
    .overrun_evt(overrun_evt)
);

// File: tb/osr_uart_rx_bench.sv
// Bench: queue model compared every clock between transfers, plus
// directed checks at the boundaries.
module osr_uart_rx_bench;
    localparam int DEPTH = 64;

    logic        clk = 1'b0, rst_n = 1'b0, rx = 1'b1, rd_strobe = 1'b0;
    logic [7:0]  rate = 8'd0;
    logic [2:0]  trig_sel = 3'd0;
    logic [1:0]  tmo_sel = 2'd0;
    logic [10:0] rd_word;
    logic [7:0]  fill_level;
    logic        trig_irq, tmo_irq, overrun_evt, frame_evt, break_evt;

    int n_checks = 0, n_fail = 0;
    int ovr_seen = 0, fe_seen = 0, brk_seen = 0, ovr_exp = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    logic [10:0] model_q[$];

    always #10 clk = ~clk;

    osr_uart_rx u_osr_uart_rx (
        .clk(clk), .rst_n(rst_n), .rx_line(rx), .rate_sel(rate),
        .trig_sel(trig_sel), .tmo_sel(tmo_sel), .rd_strobe(rd_strobe),
        .rd_word(rd_word), .fill_level(fill_level), .trig_irq(trig_irq),
        .tmo_irq(tmo_irq), .overrun_evt(overrun_evt), .frame_evt(frame_evt),
        .break_evt(break_evt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int thr(input logic [2:0] s);
        int t[6] = '{1, 4, 8, 16, 32, 48};
        return (s > 3'd5) ? 48 : t[s];
    endfunction

    function automatic int head_exp();
        return (model_q.size() != 0) ? int'(model_q[0]) : 'h100;
    endfunction

    // Event counters and per-clock model comparison, away from the edge.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (overrun_evt) ovr_seen++;
            if (frame_evt)   fe_seen++;
            if (break_evt)   brk_seen++;
            if (cmp_en) begin
                check(int'(fill_level) == model_q.size(), "R4 fill vs model",
                      int'(fill_level), model_q.size());
                check(int'(rd_word) == head_exp(), "R3 head word vs model",
                      int'(rd_word), head_exp());
                check(trig_irq == (model_q.size() >= thr(trig_sel)), "R5 trigger vs model",
                      int'(trig_irq), int'(model_q.size() >= thr(trig_sel)));
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive one character; stop_hi=0 gives a framing error (or break for 0x00).
    task automatic send_frame(input logic [7:0] b, input bit stop_hi);
        int bc = 14 * (int'(rate) + 1);
        cmp_en = 1'b0;
        @(negedge clk) rx = 1'b0;
        idle(bc);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            idle(bc);
        end
        rx = stop_hi;
        idle(bc);
        rx = 1'b1;
        idle(24);
        if (model_q.size() == DEPTH) ovr_exp++;
        else if (stop_hi)            model_q.push_back({3'b000, b});
        else if (b == 8'h00)         model_q.push_back(11'h400);
        else                         model_q.push_back({3'b010, b});
        cmp_en = 1'b1;
    endtask

    task automatic send_break();
        int bc = 14 * (int'(rate) + 1);
        cmp_en = 1'b0;
        @(negedge clk) rx = 1'b0;
        idle(12 * bc);
        rx = 1'b1;
        idle(24);
        model_q.push_back(11'h400);
        cmp_en = 1'b1;
    endtask

    task automatic read_check(input string req);
        cmp_en = 1'b0;
        @(negedge clk);
        check(int'(rd_word) == head_exp(), req, int'(rd_word), head_exp());
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        if (model_q.size() != 0) void'(model_q.pop_front());
        cmp_en = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL R1 watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(5);
        @(negedge clk) rst_n = 1'b1;
        idle(2);
        // Reset state.
        check(fill_level == 8'd0, "R4 reset fill", int'(fill_level), 0);
        check(rd_word == 11'h100, "R3 reset word", int'(rd_word), 'h100);
        check(!trig_irq && !tmo_irq, "R5 R6 reset requests", int'({trig_irq, tmo_irq}), 0);
        cmp_en = 1'b1;

        // R2: basic characters, including a zero byte with good stop.
        send_frame(8'h55, 1'b1);
        send_frame(8'hA3, 1'b1);
        send_frame(8'h00, 1'b1);
        check(fill_level == 8'd3, "R4 three stored", int'(fill_level), 3);
        read_check("R2 first byte 0x55");
        read_check("R2 second byte 0xA3");
        read_check("R2 zero byte not a break");

        // R3: read of an empty queue leaves state alone.
        read_check("R3 empty read word");
        check(fill_level == 8'd0, "R3 fill after empty read", int'(fill_level), 0);
        send_frame(8'h3C, 1'b1);
        read_check("R3 next entry after empty read");

        // R1: slower divider.
        rate = 8'd2;
        send_frame(8'h96, 1'b1);
        send_frame(8'h01, 1'b1);
        read_check("R1 byte at rate 2");
        read_check("R1 second byte at rate 2");
        rate = 8'd0;

        // R10: short low pulse.
        @(negedge clk) rx = 1'b0;
        idle(4);
        rx = 1'b1;
        idle(200);
        check(fill_level == 8'd0, "R10 glitch stores nothing", int'(fill_level), 0);

        // R5: thresholds.
        trig_sel = 3'd2;
        for (int i = 0; i < 7; i++) send_frame(8'(8'h10 + i), 1'b1);
        check(!trig_irq, "R5 below 8", int'(trig_irq), 0);
        send_frame(8'h17, 1'b1);
        check(trig_irq, "R5 at 8", int'(trig_irq), 1);
        @(negedge clk) trig_sel = 3'd3;
        @(negedge clk) check(!trig_irq, "R5 sel 3 needs 16", int'(trig_irq), 0);
        @(negedge clk) trig_sel = 3'd1;
        @(negedge clk) check(trig_irq, "R5 sel 1 needs 4", int'(trig_irq), 1);
        @(negedge clk) trig_sel = 3'd7;
        @(negedge clk) check(!trig_irq, "R5 sel 7 means 48", int'(trig_irq), 0);
        @(negedge clk) trig_sel = 3'd0;
        for (int i = 0; i < 8; i++) read_check("R4 order after trigger test");

        // R6: idle timeout.
        @(negedge clk) tmo_sel = 2'd1;
        send_frame(8'h42, 1'b1);
        idle(470);
        check(!tmo_irq, "R6 before 4 chars", int'(tmo_irq), 0);
        idle(110);
        check(tmo_irq, "R6 after 4 chars", int'(tmo_irq), 1);
        @(negedge clk) tmo_sel = 2'd2;
        @(negedge clk) check(!tmo_irq, "R6 sel 2 needs 8 chars", int'(tmo_irq), 0);
        @(negedge clk) tmo_sel = 2'd0;
        idle(2000);
        check(!tmo_irq, "R6 disabled", int'(tmo_irq), 0);
        @(negedge clk) tmo_sel = 2'd1;
        @(negedge clk) check(tmo_irq, "R6 re-enabled after long idle", int'(tmo_irq), 1);
        read_check("R6 read byte 0x42");
        check(!tmo_irq, "R6 cleared by read", int'(tmo_irq), 0);
        @(negedge clk) tmo_sel = 2'd0;

        // R8: framing error.
        send_frame(8'h5A, 1'b0);
        check(fe_seen == 1 && brk_seen == 0, "R8 frame event", fe_seen * 16 + brk_seen, 16);
        read_check("R8 flagged entry 0x25A");

        // R9: break.
        send_break();
        check(brk_seen == 1 && fe_seen == 1, "R9 break event", brk_seen * 16 + fe_seen, 17);
        check(fill_level == 8'd1, "R9 single entry", int'(fill_level), 1);
        read_check("R9 break entry 0x400");

        // R7: overrun at 64 entries.
        for (int i = 0; i < DEPTH; i++) send_frame(8'(i), 1'b1);
        check(fill_level == 8'd64, "R4 full at 64", int'(fill_level), 64);
        check(ovr_seen == 0, "R7 no overrun yet", ovr_seen, 0);
        send_frame(8'hEE, 1'b1);
        check(ovr_seen == 1 && ovr_exp == 1, "R7 overrun event", ovr_seen, 1);
        check(fill_level == 8'd64, "R7 fill held", int'(fill_level), 64);
        for (int i = 0; i < DEPTH; i++) read_check("R7 stored order, extra discarded");
        check(fill_level == 8'd0, "R4 drained", int'(fill_level), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule